// File: doc/BRIEF.md
# Output Compare Unit with Multi-Pin Forcing

This block is the output-compare part of a timer. A 16-bit counter advances by one on every cycle in which the `tick` input is high. Five compare channels watch the counter. One is the master channel and four are ordinary channels. When the counter steps onto a channel's compare value, the channel's event flag is raised.

Each ordinary channel also applies a 2-bit action to its own output line: it leaves the line alone, toggles it, drives it low or drives it high. The master channel owns a 5-bit line mask and a 5-bit line data register. On its match it writes several output lines at once, so a single compare event can set up a whole group of lines in the same cycle.

Five flags, five interrupt enables and one combined interrupt output let software either poll or take interrupts. A simple synchronous write / combinational read register bus gives access to every register.

Top module: `ocu_force`

## Requirements
- R1: The counter resets to 0 and advances by exactly one on each clock edge with `tick` high, wrapping from 0xFFFF to 0; it holds when `tick` is low and reads at address 0.
- R2: Channel k matches on the edge where the counter steps from a value onto its compare register; the match sets flag bit k (bit 0 master, bits 1..4 ordinary channels 0..3) in the flag register at address 7. Compare registers sit at addresses 1 (master) and 2..5 (ordinary 0..3).
- R3: Ordinary channel i drives output line 3+i (`lines` bit i). Its action field sits at bits [2i+1:2i] of address 6: 01 toggles the line on a match, 10 clears it and 11 sets it.
- R4: A flag clears only when 1 is written to its bit at address 7; writing 0 leaves it unchanged, and a match in the same cycle as the clear keeps the flag set.
- R5: `irq` is high exactly when some flag and its enable bit (address 8, same bit layout as the flags) are both 1.
- R6: On a master match, every line whose force-mask bit is 1 takes the matching force-data bit, and lines whose mask bit is 0 keep their value.
- R7: Force mask (address 9), force data (address 10) and the line state (address 11) use bits 7..3 for lines 7..3; bits 2..0 read as 0.
- R8: After reset all compare, action, flag, enable, mask and data registers and all output lines are 0, and `irq` is low.
- R9: With action 00 the line is left unchanged, while the flag and interrupt still work.
- R10: When the master channel and an ordinary channel act on the same line in the same cycle, the master's data value wins.
- R11: Writing a compare value equal to the current count gives no match on the next tick; the match comes only after the counter has wrapped back to that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter advance enable |
| we | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| lines | output | 5 | Output lines 3..7 (bit 0 = line 3) |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is R11. The compare value equals the count already held, so the match cannot come from the next tick. It can only come after the counter has gone all the way round. The bench writes that value, then drives 65535 ticks and checks that the flag is still clear. It drives one more tick and checks that the flag is set and that the count has returned to the starting value. The clash of R10 is set up by placing the master and an ordinary compare on the same future count, so both fire on one edge.

// File: rtl/ocu_force.sv
module ocu_force #(
  parameter int CW   = 16,
  parameter int NORD = 4,
  parameter int AW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [NORD:0] lines,
  output logic          irq
);
  localparam int NCH = NORD + 1;
  localparam int NL  = NORD + 1;
  localparam int LO  = 3;
  localparam logic [AW-1:0] A_CNT = 0, A_ACT = AW'(NCH + 1), A_FLG = AW'(NCH + 2),
                            A_IEN = AW'(NCH + 3), A_FMK = AW'(NCH + 4),
                            A_FDT = AW'(NCH + 5), A_LIN = AW'(NCH + 6);

  logic [CW-1:0]     cnt;
  logic [CW-1:0]     cmp [NCH];
  logic [2*NORD-1:0] act;
  logic [NCH-1:0]    flg, ien, hit, clr;
  logic [NL-1:0]     fmk, fdt, pin_q, pin_d;

  wire [CW-1:0] cnt_nx = cnt + 1'b1;

  for (genvar k = 0; k < NCH; k++) begin : g_hit
    assign hit[k] = tick && (cnt_nx == cmp[k]);
  end

  assign clr   = (we && addr == A_FLG) ? wdata[NCH-1:0] : '0;
  assign lines = pin_q;
  assign irq   = |(flg & ien);

  always_comb begin
    pin_d = pin_q;
    for (int i = 0; i < NORD; i++)
      if (hit[i+1])
        case (act[2*i +: 2])
          2'b01:   pin_d[i] = ~pin_q[i];
          2'b10:   pin_d[i] = 1'b0;
          2'b11:   pin_d[i] = 1'b1;
          default: pin_d[i] = pin_q[i];
        endcase
    if (hit[0]) pin_d = (pin_d & ~fmk) | (fdt & fmk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      act   <= '0;
      flg   <= '0;
      ien   <= '0;
      fmk   <= '0;
      fdt   <= '0;
      pin_q <= '0;
      for (int k = 0; k < NCH; k++) cmp[k] <= '0;
    end else begin
      if (tick) cnt <= cnt_nx;
      for (int k = 0; k < NCH; k++)
        if (we && addr == AW'(k + 1)) cmp[k] <= wdata;
      if (we && addr == A_ACT) act <= wdata[2*NORD-1:0];
      if (we && addr == A_IEN) ien <= wdata[NCH-1:0];
      if (we && addr == A_FMK) fmk <= wdata[LO +: NL];
      if (we && addr == A_FDT) fdt <= wdata[LO +: NL];
      flg   <= (flg & ~clr) | hit;
      pin_q <= pin_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NCH; k++)
      if (addr == AW'(k + 1)) rdata = cmp[k];
    case (addr)
      A_CNT:   rdata = cnt;
      A_ACT:   rdata = CW'(act);
      A_FLG:   rdata = CW'(flg);
      A_IEN:   rdata = CW'(ien);
      A_FMK:   rdata = CW'({fmk, 3'b000});
      A_FDT:   rdata = CW'({fdt, 3'b000});
      A_LIN:   rdata = CW'({pin_q, 3'b000});
      default: ;
    endcase
  end

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == CW'($past(cnt) + 1'b1));
  a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  for (genvar k = 0; k < NCH; k++) begin : g_chk
    a_r2_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      hit[k] |=> flg[k]);
  end
  a_r4_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flg) & ~flg)) |-> $past(we && addr == A_FLG));
  a_r3_lines_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lines));
  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien != '0));
endmodule

// File: tb/sim_ocu_force.sv
module sim_ocu_force;
  logic        clk = 0, rst_n = 0, tick = 0, we = 0;
  logic [3:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [4:0]  lines;
  logic        irq;
  int tests = 0, fails = 0;
  bit done = 0;

  ocu_force u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .we(we), .addr(addr),
                .wdata(wdata), .rdata(rdata), .lines(lines), .irq(irq));

  always #5 clk = ~clk;

  // {initial line value, action code, expected line after match}
  localparam logic [3:0] VEC [8] = '{
    4'b0_00_0, 4'b0_01_1, 4'b0_10_0, 4'b0_11_1,
    4'b1_00_1, 4'b1_01_0, 4'b1_10_0, 4'b1_11_1 };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic tickn(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c, l;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, v);  chk("R8 count", v, 16'h0000);
    rd(6, v);  chk("R8 action", v, 16'h0000);
    rd(7, v);  chk("R8 flags", v, 16'h0000);
    rd(9, v);  chk("R8 force mask", v, 16'h0000);
    chk("R8 lines", {11'b0, lines}, 16'h0000);
    chk("R8 irq", {15'b0, irq}, 16'h0000);

    for (int i = 0; i < 8; i++) begin
      wr(6, 16'h0000);
      wr(9, 16'h0008);
      wr(10, {12'b0, VEC[i][3], 3'b000});
      rd(0, c); wr(1, c + 16'd2); tickn(2);
      wr(9, 16'h0000);
      wr(6, {14'b0, VEC[i][2:1]});
      wr(7, 16'h001F);
      rd(0, c); wr(2, c + 16'd2); tickn(2);
      rd(11, v); chk("R3 action vector", {15'b0, v[3]}, {15'b0, VEC[i][0]});
      rd(7, v);  chk("R2 flag on match", {15'b0, v[1]}, 16'h0001);
    end

    rd(0, c); tickn(5); rd(0, v);
    chk("R1 count advance", v, c + 16'd5);

    wr(8, 16'h0000); @(negedge clk);
    chk("R5 irq masked", {15'b0, irq}, 16'h0000);
    wr(8, 16'h0002); @(negedge clk);
    chk("R5 irq enabled", {15'b0, irq}, 16'h0001);
    wr(7, 16'h0000); rd(7, v);
    chk("R4 write 0 keeps flag", {15'b0, v[1]}, 16'h0001);
    wr(7, 16'h0002); rd(7, v);
    chk("R4 write 1 clears", {15'b0, v[1]}, 16'h0000);
    chk("R5 irq drops", {15'b0, irq}, 16'h0000);

    wr(6, 16'h0000);
    rd(11, l);
    wr(9, 16'h0090); wr(10, 16'h0080);
    rd(0, c); wr(1, c + 16'd2); tickn(2);
    rd(11, v); chk("R6 master force", v, (l & ~16'h0090) | 16'h0080);

    wr(9, 16'hFFFF); rd(9, v); chk("R7 mask low bits", v, 16'h00F8);
    wr(10, 16'hFFFF); rd(10, v); chk("R7 data low bits", v, 16'h00F8);
    wr(9, 16'h0000);

    wr(7, 16'h001F);
    rd(11, l);
    rd(0, c); wr(4, c + 16'd2); tickn(2);
    rd(11, v); chk("R9 action 00 leaves line", v, l);
    rd(7, v);  chk("R9 flag still set", {15'b0, v[3]}, 16'h0001);

    wr(6, 16'h0003);
    wr(9, 16'h0008); wr(10, 16'h0000);
    rd(0, c); wr(1, c + 16'd2); wr(2, c + 16'd2); tickn(2);
    rd(11, v); chk("R10 master wins", {15'b0, v[3]}, 16'h0000);

    wr(6, 16'h0000); wr(9, 16'h0000); wr(7, 16'h001F);
    rd(0, c); wr(5, c);
    tickn(65535);
    rd(7, v); chk("R11 no early match", {15'b0, v[4]}, 16'h0000);
    tickn(1);
    rd(7, v); chk("R11 match after wrap", {15'b0, v[4]}, 16'h0001);
    rd(0, v); chk("R1 wrap returns count", v, c);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule